// File: doc/BRIEF.md
# Folded 64-Point Inverse FFT

This block turns one frame of 64 frequency-domain complex bins into 64 time-domain complex samples, the core step of an OFDM transmitter. A whole frame is presented in parallel on two packed buses (real and imaginary) and is taken in over a valid/ready handshake. The transform is split into three radix-4 passes. The block has a single physical pass of 16 four-input butterflies with their twiddle multipliers and the wiring that reorders the results. It applies this pass three times to a 64-entry working register, and a pass counter selects the twiddle angles for each pass.

Each pass divides its butterfly sums by four with round-half-up, so the three passes together scale by 1/64 and the result keeps the 16-bit range. After the third pass, a fixed index remap puts the samples back into natural time order and loads them into an output register. That register holds the result until the consumer accepts it. The block takes a new frame only while it is idle, and the time from input to output is fixed.

Top module: `ifft64_folded`

## Requirements
- R1: Bin k of the input frame is the signed 16-bit pair in_re[k], in_im[k], which sits at bits [16k+15:16k] of each input bus. The frame is captured on the rising clock edge where in_valid and in_ready are both high.
- R2: Output sample n is out_re[n], out_im[n], at bits [16n+15:16n]. In natural order, it is within 2 LSB of (1/64)·Σk X[k]·e^(+j2πkn/64), where X[k] is input bin k.
- R3: in_ready is high exactly when the block is idle, meaning no frame is being transformed and no result is waiting for acceptance.
- R4: out_valid rises exactly four clock cycles after the accepting edge, whatever the data values.
- R5: While out_valid is high and out_ready is low, out_valid stays high and out_re/out_im do not change. On the edge where both are high, the result is handed over. In the following cycle out_valid is low and in_ready is high.
- R6: Each pass divides by four with round-half-up, and the butterfly leg without a twiddle is passed through unmultiplied. As a result, a frame whose only non-zero bin is bin 0 with real value 64·c (|c| ≤ 500) gives exactly c on every real output and exactly 0 on every imaginary output.
- R7: While reset is low and after it is released, in_ready is 1 and out_valid is 0.
- R8: in_valid and the input buses are ignored while the block is not idle. A frame offered during that time is not captured and produces no output, and the result of the frame already inside is unchanged.
- R9: Full-scale frames, with every bin at +32767 or every bin at -32768, do not wrap. They meet the accuracy of R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A frame is offered on in_re/in_im |
| in_ready | output | 1 | Block is idle and will take a frame |
| in_re | input | 1024 | Real parts of the 64 bins, 16 bits each |
| in_im | input | 1024 | Imaginary parts of the 64 bins, 16 bits each |
| out_valid | output | 1 | Transformed frame is present |
| out_ready | input | 1 | Consumer accepts the frame this cycle |
| out_re | output | 1024 | Real parts of the 64 time samples, 16 bits each |
| out_im | output | 1024 | Imaginary parts of the 64 time samples, 16 bits each |

## Verification
The hardest state to reach from the ports is a frame that is held at the output while a second frame is offered at the input. Here the handshake must refuse the newcomer, and the held data must not be disturbed. To get there, the stimulus keeps out_ready low, sends one frame, and then drives a different frame with in_valid high through the whole computation and the held period. It then releases the output and compares the result with the first frame only. Accuracy is probed with exact DC frames, single-tone and two-tone frames whose tones land on different digit-reversal slots, full-scale frames and pseudo-random frames, all against a floating-point inverse DFT.

// File: rtl/ifft64_pkg.sv
package ifft64_pkg;
  localparam int PTS    = 64;            // transform size
  localparam int RADIX  = 4;
  localparam int NBFLY  = PTS / RADIX;   // butterflies per pass
  localparam int NPASS  = 3;             // log4(PTS)
  localparam int AW     = $clog2(PTS);   // sample index width
  localparam int DW     = 16;            // data width per component
  localparam int TWW    = 16;            // twiddle width, Q1.15
  localparam int LAT    = NPASS + 1;     // accept edge to out_valid

  typedef struct packed {
    logic signed [DW-1:0] re;
    logic signed [DW-1:0] im;
  } cpx_t;

  // sin(2*pi*k/64) in Q1.15 for the first quadrant, k = 0..16
  function automatic logic signed [TWW-1:0] qsin(input logic [4:0] k);
    case (k)
      5'd0:    return 16'sd0;
      5'd1:    return 16'sd3212;
      5'd2:    return 16'sd6393;
      5'd3:    return 16'sd9512;
      5'd4:    return 16'sd12539;
      5'd5:    return 16'sd15446;
      5'd6:    return 16'sd18204;
      5'd7:    return 16'sd20787;
      5'd8:    return 16'sd23170;
      5'd9:    return 16'sd25329;
      5'd10:   return 16'sd27245;
      5'd11:   return 16'sd28898;
      5'd12:   return 16'sd30273;
      5'd13:   return 16'sd31356;
      5'd14:   return 16'sd32137;
      5'd15:   return 16'sd32609;
      5'd16:   return 16'sd32767;
      default: return 16'sd0;
    endcase
  endfunction

  // e^(+j*2*pi*e/64): re = cosine, im = sine (positive sign for the inverse)
  function automatic cpx_t twiddle(input logic [AW-1:0] e);
    logic [4:0] rlo;
    logic [4:0] rhi;
    logic signed [TWW-1:0] s;
    logic signed [TWW-1:0] c;
    cpx_t t;
    rlo = {1'b0, e[3:0]};
    rhi = 5'd16 - rlo;
    s = qsin(rlo);
    c = qsin(rhi);
    case (e[5:4])
      2'd0:    begin t.re = c;  t.im = s;  end
      2'd1:    begin t.re = -s; t.im = c;  end
      2'd2:    begin t.re = -c; t.im = -s; end
      default: begin t.re = s;  t.im = -c; end
    endcase
    return t;
  endfunction

  // reverse the base-4 digits of a sample index
  function automatic logic [AW-1:0] digit_rev(input logic [AW-1:0] a);
    logic [AW-1:0] r;
    for (int d = 0; d < NPASS; d++) r[2*d +: 2] = a[AW-2-2*d +: 2];
    return r;
  endfunction
endpackage

// File: rtl/ifft64_bfly4.sv
module ifft64_bfly4
  import ifft64_pkg::*;
(
  input  cpx_t [RADIX-1:0] x,
  output cpx_t [RADIX-1:0] y
);
  localparam int SW = DW + 2;

  function automatic logic signed [SW-1:0] sx(input logic signed [DW-1:0] v);
    return {{2{v[DW-1]}}, v};
  endfunction

  // divide by four, round half up
  function automatic logic signed [DW-1:0] q4(input logic signed [SW-1:0] v);
    logic signed [SW-1:0] t;
    t = v + SW'(2);
    return t[SW-1:2];
  endfunction

  logic signed [SW-1:0] a_re, a_im, b_re, b_im, c_re, c_im, d_re, d_im;

  always_comb begin
    a_re = sx(x[0].re) + sx(x[2].re);
    a_im = sx(x[0].im) + sx(x[2].im);
    b_re = sx(x[0].re) - sx(x[2].re);
    b_im = sx(x[0].im) - sx(x[2].im);
    c_re = sx(x[1].re) + sx(x[3].re);
    c_im = sx(x[1].im) + sx(x[3].im);
    d_re = sx(x[1].re) - sx(x[3].re);
    d_im = sx(x[1].im) - sx(x[3].im);
    y[0].re = q4(a_re + c_re);
    y[0].im = q4(a_im + c_im);
    y[2].re = q4(a_re - c_re);
    y[2].im = q4(a_im - c_im);
    // leg 1 uses +j*D, leg 3 uses -j*D
    y[1].re = q4(b_re - d_im);
    y[1].im = q4(b_im + d_re);
    y[3].re = q4(b_re + d_im);
    y[3].im = q4(b_im - d_re);
  end
endmodule

// File: rtl/ifft64_twmul.sv
module ifft64_twmul
  import ifft64_pkg::*;
(
  input  cpx_t          z,
  input  logic [AW-1:0] ex,
  output cpx_t          w
);
  localparam int FR  = TWW - 1;
  localparam int PW  = DW + TWW + 1;
  localparam int SRW = PW - FR;

  function automatic logic signed [DW-1:0] sat(input logic [SRW-1:0] v);
    if (!v[SRW-1] && (|v[SRW-2:DW-1]))      return {1'b0, {(DW-1){1'b1}}};
    else if (v[SRW-1] && !(&v[SRW-2:DW-1])) return {1'b1, {(DW-1){1'b0}}};
    else                                    return v[DW-1:0];
  endfunction

  cpx_t t;
  logic signed [PW-1:0] zr, zi, tr, ti, pr, pi, rr, ri;

  always_comb begin
    t  = twiddle(ex);
    zr = PW'(z.re);
    zi = PW'(z.im);
    tr = PW'(t.re);
    ti = PW'(t.im);
    pr = zr * tr - zi * ti;
    pi = zr * ti + zi * tr;
    rr = pr + (PW'(1) <<< (FR - 1));
    ri = pi + (PW'(1) <<< (FR - 1));
    if (ex == '0) begin
      w = z;
    end else begin
      w.re = sat(rr[PW-1:FR]);
      w.im = sat(ri[PW-1:FR]);
    end
  end
endmodule

// File: rtl/ifft64_pass.sv
module ifft64_pass
  import ifft64_pkg::*;
(
  input  cpx_t [PTS-1:0] d,
  input  logic [1:0]     pass_idx,
  output cpx_t [PTS-1:0] q
);
  for (genvar j = 0; j < NBFLY; j++) begin : g_bf
    cpx_t [RADIX-1:0] bin;
    cpx_t [RADIX-1:0] bout;
    logic [AW-1:0]    base;

    // fixed gather: leg g of butterfly j reads slot j + g*NBFLY
    for (genvar g = 0; g < RADIX; g++) begin : g_in
      assign bin[g] = d[j + g*NBFLY];
    end

    ifft64_bfly4 u_bfly (.x(bin), .y(bout));

    // twiddle base: low pass-index digits of j cleared
    always_comb base = AW'(j) & (AW'({AW{1'b1}}) << (2 * pass_idx));

    // fixed scatter: leg p of butterfly j writes slot RADIX*j + p
    for (genvar p = 0; p < RADIX; p++) begin : g_out
      if (p == 0) begin : g_pass
        assign q[RADIX*j] = bout[0];
      end else begin : g_mul
        logic [AW-1:0] ex;
        always_comb ex = AW'(base * AW'(p));
        ifft64_twmul u_tw (.z(bout[p]), .ex(ex), .w(q[RADIX*j + p]));
      end
    end
  end
endmodule

// File: rtl/ifft64_folded.sv
module ifft64_folded
  import ifft64_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [PTS-1:0][DW-1:0] in_re,
  input  logic [PTS-1:0][DW-1:0] in_im,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [PTS-1:0][DW-1:0] out_re,
  output logic [PTS-1:0][DW-1:0] out_im
);
  typedef enum logic [1:0] {ST_IDLE, ST_CALC, ST_EMIT, ST_HOLD} state_t;

  state_t         state_q, state_d;
  logic [1:0]     pass_q, pass_d;
  logic           work_en, load_sel, out_en;
  cpx_t [PTS-1:0] work_q, work_d, pass_out;

  ifft64_pass u_pass (.d(work_q), .pass_idx(pass_q), .q(pass_out));

  // next-state logic
  always_comb begin
    state_d  = state_q;
    pass_d   = pass_q;
    work_en  = 1'b0;
    load_sel = 1'b0;
    out_en   = 1'b0;
    case (state_q)
      ST_IDLE: if (in_valid) begin
        state_d  = ST_CALC;
        pass_d   = '0;
        work_en  = 1'b1;
        load_sel = 1'b1;
      end
      ST_CALC: begin
        work_en = 1'b1;
        if (pass_q == 2'(NPASS - 1)) state_d = ST_EMIT;
        else                         pass_d  = pass_q + 2'd1;
      end
      ST_EMIT: begin
        out_en  = 1'b1;
        state_d = ST_HOLD;
      end
      default: if (out_ready) state_d = ST_IDLE;
    endcase
  end

  for (genvar k = 0; k < PTS; k++) begin : g_ld
    always_comb begin
      if (load_sel) begin
        work_d[k].re = in_re[k];
        work_d[k].im = in_im[k];
      end else begin
        work_d[k] = pass_out[k];
      end
    end
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pass_q  <= '0;
    end else begin
      state_q <= state_d;
      pass_q  <= pass_d;
    end
  end

  // datapath registers, enabled only
  always_ff @(posedge clk) begin
    if (work_en) work_q <= work_d;
  end

  for (genvar n = 0; n < PTS; n++) begin : g_out
    localparam logic [AW-1:0] SRC = digit_rev(AW'(n));
    always_ff @(posedge clk) begin
      if (out_en) begin
        out_re[n] <= work_q[SRC].re;
        out_im[n] <= work_q[SRC].im;
      end
    end
  end

  assign in_ready  = (state_q == ST_IDLE);
  assign out_valid = (state_q == ST_HOLD);
endmodule

// File: rtl/ifft64_checker.sv
module ifft64_checker
  import ifft64_pkg::*;
(
  input logic                   clk,
  input logic                   rst_n,
  input logic                   in_valid,
  input logic                   in_ready,
  input logic                   out_valid,
  input logic                   out_ready,
  input logic [PTS-1:0][DW-1:0] out_re,
  input logic [PTS-1:0][DW-1:0] out_im
);
  logic [LAT-1:0] acc_sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_sr <= '0;
    else        acc_sr <= {acc_sr[LAT-2:0], in_valid && in_ready};
  end

  a_r3_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  a_r5_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_re) && $stable(out_im));

  a_r5_release: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready |=> !out_valid && in_ready);

  a_r4_latency: assert property (@(posedge clk) disable iff (!rst_n)
    acc_sr[LAT-1] |=> $rose(out_valid));

  a_r4_no_early: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(acc_sr[LAT-1]));

  a_r8_no_capture_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (|acc_sr[LAT-2:0]) |-> !in_ready);
endmodule

bind ifft64_folded ifft64_checker u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_re(out_re), .out_im(out_im)
);

// File: tb/tb_ifft64_folded.sv
`timescale 1ns/1ps
module tb_ifft64_folded;
  import ifft64_pkg::*;

  typedef logic signed [PTS-1:0][31:0] ivec_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [PTS-1:0][DW-1:0] in_re = '0;
  logic [PTS-1:0][DW-1:0] in_im = '0;
  logic out_valid;
  logic out_ready = 1'b0;
  logic [PTS-1:0][DW-1:0] out_re;
  logic [PTS-1:0][DW-1:0] out_im;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int sre[PTS];
  int sim[PTS];

  ivec_t exp_re_q[$];
  ivec_t exp_im_q[$];
  int    tol_q[$];
  string tag_q[$];
  int    acc_q[$];

  ifft64_folded dut (.*);

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  function automatic int rnd(input real x);
    return (x >= 0.0) ? $rtoi(x + 0.5) : -$rtoi(-x + 0.5);
  endfunction

  function automatic int iabs(input int v);
    return (v < 0) ? -v : v;
  endfunction

  task automatic clear_stim();
    for (int k = 0; k < PTS; k++) begin sre[k] = 0; sim[k] = 0; end
  endtask

  // driver: reference inverse DFT into the scoreboard, then offer the frame
  task automatic send(input string tag, input int tol);
    ivec_t er, ei;
    real ar, ai, ang;
    for (int n = 0; n < PTS; n++) begin
      ar = 0.0; ai = 0.0;
      for (int k = 0; k < PTS; k++) begin
        ang = 2.0 * 3.14159265358979 * real'((k * n) % PTS) / real'(PTS);
        ar += real'(sre[k]) * $cos(ang) - real'(sim[k]) * $sin(ang);
        ai += real'(sre[k]) * $sin(ang) + real'(sim[k]) * $cos(ang);
      end
      er[n] = rnd(ar / real'(PTS));
      ei[n] = rnd(ai / real'(PTS));
    end
    @(negedge clk);
    for (int k = 0; k < PTS; k++) begin
      in_re[k] = DW'(sre[k]);
      in_im[k] = DW'(sim[k]);
    end
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    exp_re_q.push_back(er);
    exp_im_q.push_back(ei);
    tol_q.push_back(tol);
    tag_q.push_back(tag);
    acc_q.push_back(cyc + 1);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // monitor: samples 1 ns after the falling edge
  initial begin
    bit prev_v = 1'b0;
    bit want_ready = 1'b0;
    forever begin
      @(negedge clk);
      #1;
      if (rst_n) begin
        if (want_ready) begin
          check(in_ready === 1'b1, "R5", "in_ready after handoff", int'(in_ready), 1);
          check(out_valid === 1'b0, "R5", "out_valid after handoff", int'(out_valid), 0);
          want_ready = 1'b0;
        end
        if (out_valid && !prev_v) begin
          if (acc_q.size() == 0) check(1'b0, "R8", "output with no frame accepted", 1, 0);
          else begin
            int a;
            a = acc_q.pop_front();
            check(cyc - a == LAT, "R4", "accept-to-valid cycles", cyc - a, LAT);
          end
        end
        if (out_valid && out_ready) begin
          if (exp_re_q.size() == 0) check(1'b0, "R8", "unexpected frame", 1, 0);
          else begin
            ivec_t er, ei;
            int tol, bad, gr, gi;
            string tg;
            er = exp_re_q.pop_front();
            ei = exp_im_q.pop_front();
            tol = tol_q.pop_front();
            tg = tag_q.pop_front();
            bad = -1;
            for (int n = 0; n < PTS; n++) begin
              gr = int'($signed(out_re[n]));
              gi = int'($signed(out_im[n]));
              if (bad < 0 && (iabs(gr - int'(er[n])) > tol || iabs(gi - int'(ei[n])) > tol)) bad = n;
            end
            if (bad < 0) check(1'b1, tg, "frame", 0, 0);
            else begin
              check(1'b0, tg, $sformatf("sample %0d re", bad), int'($signed(out_re[bad])), int'(er[bad]));
              $display("  (sample %0d im actual %0d expected %0d, tolerance %0d)", bad,
                       int'($signed(out_im[bad])), int'(ei[bad]), tol);
            end
          end
          want_ready = 1'b1;
        end
      end
      prev_v = out_valid;
    end
  end

  // watchdog
  initial begin
    #(4 * 150000);
    check(1'b0, "R4", "watchdog expired, frames pending", exp_re_q.size(), 0);
    finish_run();
  end

  initial begin
    // R7: reset state
    repeat (3) @(negedge clk);
    check(in_ready === 1'b1, "R7", "in_ready in reset", int'(in_ready), 1);
    check(out_valid === 1'b0, "R7", "out_valid in reset", int'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready === 1'b1, "R7", "in_ready after reset", int'(in_ready), 1);
    check(out_valid === 1'b0, "R7", "out_valid after reset", int'(out_valid), 0);
    out_ready = 1'b1;

    // R6: exact DC scaling, both signs; R1 bin 0 position
    clear_stim(); sre[0] = 6400;  send("R6", 0);
    clear_stim(); sre[0] = -6400; send("R6", 0);
    clear_stim(); sre[0] = 64;    send("R6", 0);

    // R2: single tones and mixtures that hit different reversal slots
    clear_stim(); sre[1] = 16000;                send("R2", 2);
    clear_stim(); sim[63] = -12000;              send("R2", 2);
    clear_stim(); sre[5] = 9000; sim[40] = 7000; send("R2", 2);
    clear_stim(); sre[32] = 32000;               send("R2", 2);
    clear_stim(); sre[21] = -20000; sre[42] = 15000; sim[11] = 11000; send("R1", 2);

    // R9: full scale, no wrap
    clear_stim(); for (int k = 0; k < PTS; k++) begin sre[k] = 32767; sim[k] = 32767; end send("R9", 2);
    clear_stim(); for (int k = 0; k < PTS; k++) sre[k] = -32768; send("R9", 2);

    // R2: pseudo-random frames
    for (int f = 0; f < 6; f++) begin
      for (int k = 0; k < PTS; k++) begin
        sre[k] = int'($urandom_range(6000)) - 3000;
        sim[k] = int'($urandom_range(6000)) - 3000;
      end
      send("R2", 2);
    end

    // R8/R5: hold the result and offer a second frame throughout
    repeat (8) @(negedge clk);
    out_ready = 1'b0;
    clear_stim(); sre[3] = 14000; sim[9] = -9000; send("R8", 2);
    for (int i = 0; i < 8; i++) begin
      for (int k = 0; k < PTS; k++) begin
        in_re[k] = DW'(1000 * (k % 7) - 3000);
        in_im[k] = DW'(-500 * (k % 5));
      end
      in_valid = 1'b1;
      #1;
      check(in_ready === 1'b0, "R3", "in_ready while busy", int'(in_ready), 0);
      @(negedge clk);
    end
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    check(out_valid === 1'b1, "R5", "out_valid held while stalled", int'(out_valid), 1);
    out_ready = 1'b1;

    // back-to-back frames after the stall
    clear_stim(); sre[0] = -3200; send("R6", 0);
    clear_stim(); sre[7] = 5000; sim[50] = 4000; send("R2", 2);

    while (exp_re_q.size() != 0) @(negedge clk);
    repeat (10) @(negedge clk);
    check(out_valid === 1'b0, "R8", "no output from ignored frame", int'(out_valid), 0);
    check(acc_q.size() == 0, "R8", "pending accepts", acc_q.size(), 0);
    finish_run();
  end
endmodule